// File: doc/BRIEF.md
# Processor Status and Cause Register Write Filter

This block holds two privileged control registers of a processor core, the status word and the exception cause word, and applies software writes to them. A status write goes through a writable-bit mask and then through revision-dependent rules. The rules cover bits that software may clear but never set, refusal of one privilege-level encoding, and a hierarchy among the three 64-bit address-space enables. A cause write reaches only a small fixed set of bits, plus the disable-count bit when revision-2 behaviour is on.

Some writes also produce side effects. When a write turns off an address-space enable that was on, a one-cycle pulse asks for a flush of the translation cache. When the disable-count bit changes, a stop or start request goes to the cycle counter. The two software-interrupt levels follow their cause bits. A separate timer input can set or clear the timer-pending cause bit.

All side-effect pulses are registered. They are high in the cycle in which the new register value first appears. Reading the registers has no side effects. The core sets the revision flags and holds them steady.

Top module: `psc_regs`

## Requirements
- R1: A status write changes only the bits set in `st_mask`: new = (old & ~mask) | (data & mask). Status resets to 0x00000004 (the error-level bit, bit 2). Cause resets to 0.
- R2: With `rev6` set, the status bits at positions 20 and 19 can be cleared by a write but never set. Writing 1 to either bit keeps the old value.
- R3: With `rev6` set and both privilege-field bits [4:3] writable, a write of 2'b11 to [4:3] leaves that field unchanged. If only one of the two bits is writable, the write is applied normally.
- R4: With `rev6` and `seg64` set, the written enables form a hierarchy: kernel (bit 7) = 0 forces supervisor (bit 6) to 0, and supervisor = 0 forces user (bit 5) to 0. Without `seg64`, the written enables are taken as given.
- R5: If a status write turns any of bits 7, 6 or 5 from 1 to 0, `xlat_flush` is high for exactly one cycle, the cycle in which the new status first appears.
- R6: A cause write can change only bits 23, 22, 9 and 8 (mask 0x00C00300). With `rev2` set, bit 27 (disable count) is writable as well.
- R7: With `rev6` set, cause bit 22 can be cleared by a write, but a written 1 is ignored.
- R8: A cause write that moves bit 27 from 0 to 1 pulses `cnt_stop` for one cycle. A move from 1 to 0 pulses `cnt_start` for one cycle.
- R9: `swi[1:0]` always equals cause bits [9:8].
- R10: With `rev2` set, `ti_set` sets cause bit 30 and `ti_clr` clears it. Clear wins when both are high. A cause write in the same cycle is still applied. Without `rev2`, both inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rev2 | input | 1 | Enables revision-2 behaviour |
| cfg_rev6 | input | 1 | Enables revision-6 behaviour |
| cfg_seg64 | input | 1 | Enables the 64-bit segment enable hierarchy |
| st_we | input | 1 | Status write strobe |
| st_wdata | input | 32 | Status write data |
| st_mask | input | 32 | Writable-bit mask for status |
| ca_we | input | 1 | Cause write strobe |
| ca_wdata | input | 32 | Cause write data |
| ti_set | input | 1 | Sets the timer-pending bit |
| ti_clr | input | 1 | Clears the timer-pending bit |
| status_q | output | 32 | Current status value |
| cause_q | output | 32 | Current cause value |
| xlat_flush | output | 1 | One-cycle translation-cache flush request |
| cnt_stop | output | 1 | One-cycle cycle-counter stop request |
| cnt_start | output | 1 | One-cycle cycle-counter start request |
| swi | output | 2 | Software-interrupt levels |

## Verification
Two of the block's functions can fall in the same cycle: a software cause write and a timer set or clear. Both act on the cause register, on disjoint bits. The bench asserts `ti_set` in the same cycle as a cause write that raises a software-interrupt bit. It then checks that the new cause value carries both changes. It also raises both timer inputs together and checks that clear wins. A further check confirms that without revision-2 behaviour the timer inputs leave the cause value untouched.

// File: rtl/psc_pkg.sv
package psc_pkg;
    localparam int REG_W     = 32;
    // status bit positions
    localparam int ST_ERL    = 2;
    localparam int ST_PRV_LO = 3;
    localparam int ST_PRV_HI = 4;
    localparam int ST_EXT_U  = 5;
    localparam int ST_EXT_S  = 6;
    localparam int ST_EXT_K  = 7;
    localparam int ST_NMI_F  = 19;
    localparam int ST_SOFT_R = 20;
    // cause bit positions
    localparam int CA_SWI_LO = 8;
    localparam int CA_SWI_N  = 2;
    localparam int CA_WPEND  = 22;
    localparam int CA_IVEC   = 23;
    localparam int CA_DCNT   = 27;
    localparam int CA_TPEND  = 30;
    localparam logic [REG_W-1:0] CA_BASE_MASK = 32'h00C00300;
endpackage

// File: rtl/psc_status_unit.sv
module psc_status_unit
    import psc_pkg::*;
#(
    parameter int DW = REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] wmask,
    input  logic          rev6,
    input  logic          seg64,
    output logic [DW-1:0] status_q,
    output logic          flush_o
);
    localparam logic [DW-1:0] RST_VAL = DW'(1) << ST_ERL;

    logic [DW-1:0] val_eff;
    logic [DW-1:0] msk_eff;
    logic [DW-1:0] nxt;
    logic          ext_drop;

    always_comb begin
        val_eff = wdata;
        if (rev6 && seg64) begin
            val_eff[ST_EXT_K] = wdata[ST_EXT_K];
            val_eff[ST_EXT_S] = wdata[ST_EXT_S] & val_eff[ST_EXT_K];
            val_eff[ST_EXT_U] = wdata[ST_EXT_U] & val_eff[ST_EXT_S];
        end
        msk_eff = wmask;
        if (rev6) begin
            if ((wmask[ST_PRV_HI:ST_PRV_LO] == 2'b11) &&
                (val_eff[ST_PRV_HI:ST_PRV_LO] == 2'b11))
                msk_eff[ST_PRV_HI:ST_PRV_LO] = 2'b00;
            msk_eff[ST_SOFT_R] = wmask[ST_SOFT_R] & ~val_eff[ST_SOFT_R];
            msk_eff[ST_NMI_F]  = wmask[ST_NMI_F]  & ~val_eff[ST_NMI_F];
        end
        nxt      = (status_q & ~msk_eff) | (val_eff & msk_eff);
        ext_drop = |(status_q[ST_EXT_K:ST_EXT_U] & ~nxt[ST_EXT_K:ST_EXT_U]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= RST_VAL;
            flush_o  <= 1'b0;
        end else begin
            flush_o <= we && ext_drop;
            if (we)
                status_q <= nxt;
        end
    end

    // R1: bits outside the mask keep their value
    a_r1_unmasked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (((status_q ^ $past(status_q)) & ~$past(wmask)) == '0));
    a_r1_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(status_q));
    // R2: clear-only bits
    a_r2_soft_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (we && rev6 && !status_q[ST_SOFT_R]) |=> !status_q[ST_SOFT_R]);
    a_r2_nmi_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (we && rev6 && !status_q[ST_NMI_F]) |=> !status_q[ST_NMI_F]);
    // R3: reserved privilege encoding refused
    a_r3_prv_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (we && rev6 && wmask[ST_PRV_HI:ST_PRV_LO] == 2'b11 &&
         wdata[ST_PRV_HI:ST_PRV_LO] == 2'b11)
        |=> $stable(status_q[ST_PRV_HI:ST_PRV_LO]));
    // R4: kernel enable off forces supervisor enable off
    a_r4_hier: assert property (@(posedge clk) disable iff (!rst_n)
        (we && rev6 && seg64 && !wdata[ST_EXT_K] && wmask[ST_EXT_S])
        |=> !status_q[ST_EXT_S]);
    // R5: any enable falling produces the flush pulse
    a_r5_flush_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(status_q[ST_EXT_K:ST_EXT_U]) & ~status_q[ST_EXT_K:ST_EXT_U]))
        |-> flush_o);
endmodule

// File: rtl/psc_cause_unit.sv
module psc_cause_unit
    import psc_pkg::*;
#(
    parameter int DW = REG_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [DW-1:0]       wdata,
    input  logic                rev2,
    input  logic                rev6,
    input  logic                ti_set,
    input  logic                ti_clr,
    output logic [DW-1:0]       cause_q,
    output logic                stop_o,
    output logic                start_o,
    output logic [CA_SWI_N-1:0] swi_o
);
    localparam logic [DW-1:0] LEGAL_BITS =
        DW'(CA_BASE_MASK) | (DW'(1) << CA_DCNT) | (DW'(1) << CA_TPEND);

    logic [DW-1:0] msk_eff;
    logic [DW-1:0] nxt;

    always_comb begin
        msk_eff = DW'(CA_BASE_MASK);
        if (rev2)
            msk_eff[CA_DCNT] = 1'b1;
        if (rev6)
            msk_eff[CA_WPEND] = ~wdata[CA_WPEND];
        nxt = we ? ((cause_q & ~msk_eff) | (wdata & msk_eff)) : cause_q;
        if (rev2) begin
            if (ti_clr)
                nxt[CA_TPEND] = 1'b0;
            else if (ti_set)
                nxt[CA_TPEND] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
            stop_o  <= 1'b0;
            start_o <= 1'b0;
        end else begin
            cause_q <= nxt;
            stop_o  <= we && !cause_q[CA_DCNT] && nxt[CA_DCNT];
            start_o <= we && cause_q[CA_DCNT] && !nxt[CA_DCNT];
        end
    end

    for (genvar i = 0; i < CA_SWI_N; i++) begin : g_swi
        assign swi_o[i] = cause_q[CA_SWI_LO + i];
    end

    // R6: bits outside the writable set stay zero
    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q & ~LEGAL_BITS) == '0);
    a_r6_dc_needs_rev2: assert property (@(posedge clk) disable iff (!rst_n)
        !rev2 |=> $stable(cause_q[CA_DCNT]));
    // R7: write-one to the pending-watch bit ignored
    a_r7_wp_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rev6 && !cause_q[CA_WPEND]) |=> !cause_q[CA_WPEND]);
    // R8: counter requests track the disable-count edges
    a_r8_stop_edge: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> (cause_q[CA_DCNT] && !$past(cause_q[CA_DCNT])));
    a_r8_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (!cause_q[CA_DCNT] && $past(cause_q[CA_DCNT])));
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(stop_o && start_o));
    // R10: timer inputs inert without revision-2
    a_r10_ti_inert: assert property (@(posedge clk) disable iff (!rst_n)
        !rev2 |=> $stable(cause_q[CA_TPEND]));
endmodule

// File: rtl/psc_regs.sv
module psc_regs
    import psc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_rev2,
    input  logic        cfg_rev6,
    input  logic        cfg_seg64,
    input  logic        st_we,
    input  logic [31:0] st_wdata,
    input  logic [31:0] st_mask,
    input  logic        ca_we,
    input  logic [31:0] ca_wdata,
    input  logic        ti_set,
    input  logic        ti_clr,
    output logic [31:0] status_q,
    output logic [31:0] cause_q,
    output logic        xlat_flush,
    output logic        cnt_stop,
    output logic        cnt_start,
    output logic [1:0]  swi
);
    psc_status_unit #(.DW(REG_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (st_we),
        .wdata    (st_wdata),
        .wmask    (st_mask),
        .rev6     (cfg_rev6),
        .seg64    (cfg_seg64),
        .status_q (status_q),
        .flush_o  (xlat_flush)
    );

    psc_cause_unit #(.DW(REG_W)) u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ca_we),
        .wdata   (ca_wdata),
        .rev2    (cfg_rev2),
        .rev6    (cfg_rev6),
        .ti_set  (ti_set),
        .ti_clr  (ti_clr),
        .cause_q (cause_q),
        .stop_o  (cnt_stop),
        .start_o (cnt_start),
        .swi_o   (swi)
    );

    // R9: interrupt levels follow the cause bits one cycle after a write
    a_r9_swi_follow: assert property (@(posedge clk) disable iff (!rst_n)
        ca_we |=> (swi == $past(swi) || $changed(cause_q[9:8])));
endmodule

// File: tb/sim_psc_regs.sv
module sim_psc_regs;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 13;
    // {sel, rev2, rev6, seg64, mask, wdata, expected, flush, stop, start}
    localparam logic [102:0] VEC [NV] = '{
        {1'b0,1'b0,1'b0,1'b0,32'hFFFFFFFF,32'h001800E0,32'h001800E0,1'b0,1'b0,1'b0},
        {1'b0,1'b0,1'b1,1'b1,32'hFFFFFFFF,32'h000000A0,32'h00000080,1'b1,1'b0,1'b0},
        {1'b0,1'b0,1'b1,1'b1,32'hFFFFFFFF,32'h00180018,32'h00000000,1'b1,1'b0,1'b0},
        {1'b0,1'b0,1'b1,1'b0,32'h00000010,32'h00000018,32'h00000010,1'b0,1'b0,1'b0},
        {1'b0,1'b0,1'b0,1'b0,32'h0000FF00,32'hFFFFFFFF,32'h0000FF10,1'b0,1'b0,1'b0},
        {1'b0,1'b0,1'b1,1'b0,32'hFFFFFFFF,32'h000000C0,32'h000000C0,1'b0,1'b0,1'b0},
        {1'b1,1'b0,1'b0,1'b0,32'h0,32'hFFFFFFFF,32'h00C00300,1'b0,1'b0,1'b0},
        {1'b1,1'b1,1'b0,1'b0,32'h0,32'h08000000,32'h08000000,1'b0,1'b1,1'b0},
        {1'b1,1'b1,1'b1,1'b0,32'h0,32'h00400000,32'h00000000,1'b0,1'b0,1'b1},
        {1'b1,1'b0,1'b1,1'b0,32'h0,32'h08C00100,32'h00800100,1'b0,1'b0,1'b0},
        {1'b1,1'b0,1'b0,1'b0,32'h0,32'h00400000,32'h00400000,1'b0,1'b0,1'b0},
        {1'b1,1'b0,1'b1,1'b0,32'h0,32'h00000000,32'h00000000,1'b0,1'b0,1'b0},
        {1'b1,1'b0,1'b1,1'b0,32'h0,32'h00400200,32'h00000200,1'b0,1'b0,1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_rev2 = 1'b0, cfg_rev6 = 1'b0, cfg_seg64 = 1'b0;
    logic        st_we = 1'b0, ca_we = 1'b0, ti_set = 1'b0, ti_clr = 1'b0;
    logic [31:0] st_wdata = '0, st_mask = '0, ca_wdata = '0;
    logic [31:0] status_q, cause_q;
    logic        xlat_flush, cnt_stop, cnt_start;
    logic [1:0]  swi;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psc_regs u0 (
        .clk(clk), .rst_n(rst_n), .cfg_rev2(cfg_rev2), .cfg_rev6(cfg_rev6),
        .cfg_seg64(cfg_seg64), .st_we(st_we), .st_wdata(st_wdata),
        .st_mask(st_mask), .ca_we(ca_we), .ca_wdata(ca_wdata),
        .ti_set(ti_set), .ti_clr(ti_clr), .status_q(status_q),
        .cause_q(cause_q), .xlat_flush(xlat_flush), .cnt_stop(cnt_stop),
        .cnt_start(cnt_start), .swi(swi)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        st_we = 1'b0; ca_we = 1'b0; ti_set = 1'b0; ti_clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 and reset state
        chk("R1 status reset", status_q, 32'h00000004);
        chk("R1 cause reset", cause_q, 32'h0);
        chk("R5 flush at reset", {31'b0, xlat_flush}, 32'h0);
        chk("R8 counter requests at reset", {30'b0, cnt_stop, cnt_start}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            cfg_rev2  = VEC[i][101];
            cfg_rev6  = VEC[i][100];
            cfg_seg64 = VEC[i][99];
            if (VEC[i][102]) begin
                ca_we = 1'b1; ca_wdata = VEC[i][66:35];
            end else begin
                st_we = 1'b1; st_mask = VEC[i][98:67]; st_wdata = VEC[i][66:35];
            end
            @(negedge clk);
            idle_inputs();
            if (VEC[i][102]) begin
                chk("R6 R7 cause value", cause_q, VEC[i][34:3]);
                chk("R9 swi levels", {30'b0, swi}, {30'b0, VEC[i][12:11]});
                chk("R8 stop/start", {30'b0, cnt_stop, cnt_start}, {30'b0, VEC[i][1:0]});
            end else begin
                chk("R1 R2 R3 R4 status value", status_q, VEC[i][34:3]);
                chk("R5 flush pulse", {31'b0, xlat_flush}, {31'b0, VEC[i][2]});
            end
        end

        // R10 with R9: timer set alongside a cause write
        cfg_rev2 = 1'b1; cfg_rev6 = 1'b0;
        ca_we = 1'b1; ca_wdata = 32'h00000100; ti_set = 1'b1;
        @(negedge clk); idle_inputs();
        chk("R10 timer set with cause write", cause_q, 32'h40000100);
        chk("R9 swi after combined cycle", {30'b0, swi}, 32'h1);

        // R10: no effect without revision-2
        cfg_rev2 = 1'b0; ti_clr = 1'b1;
        @(negedge clk); idle_inputs();
        chk("R10 timer clear ignored", cause_q, 32'h40000100);

        // R10: clear wins over set
        cfg_rev2 = 1'b1; ti_set = 1'b1; ti_clr = 1'b1;
        @(negedge clk); idle_inputs();
        chk("R10 clear priority", cause_q, 32'h00000100);

        // R5: pulse lasts one cycle
        cfg_rev2 = 1'b0; cfg_rev6 = 1'b0; cfg_seg64 = 1'b0;
        st_we = 1'b1; st_mask = 32'hFFFFFFFF; st_wdata = 32'h000000E0;
        @(negedge clk); idle_inputs();
        chk("R5 no flush on rise", {31'b0, xlat_flush}, 32'h0);
        st_we = 1'b1; st_wdata = 32'h00000000;
        @(negedge clk); idle_inputs();
        chk("R5 flush on fall", {31'b0, xlat_flush}, 32'h1);
        @(negedge clk);
        chk("R5 flush single cycle", {31'b0, xlat_flush}, 32'h0);
        chk("R1 status idle hold", status_q, 32'h0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule